// File: doc/BRIEF.md
# Configuration Memory Read Sequencer

This block is the read engine of a configuration memory that streams a stored bitstream into a downstream device. A registered address counter walks a small internal word array, one word per clock. Four control inputs steer it: an active-low chip enable, a combined output-enable/reset input, an active-low configuration request and a busy input. The block presents the addressed word together with a data-drive enable and a clock-output drive enable. It also produces an active-low cascade enable, so that a second memory in a chain can continue the stream once this one is exhausted.

With revisioning turned on, a 2-bit select picks one of up to four banks. Each bank is an inclusive address window held in a small register table, loaded from parameters at reset. Every address reset goes to the selected bank's first address. Reaching the bank's last address parks the counter without passing control down the chain. Reaching the top of the array parks the counter and hands over to the next device. Words are presented for the addresses before the parking address, so a window of start S and end E streams the words S through E-1. The drive enables stand in for the high-impedance pin state: when they are low, the data bus is held at zero. A write port fills the array during tests.

Top module: `cfg_rom_seq`

## Requirements
- R1: While `ce_n` is 1, the address returns to the reset target on each clock, and `dout_oe` and `clk_oe` are 0 and `ceo_n` is 1, whatever `oe_rst` is.
- R2: With `ce_n`=0, `oe_rst`=1, `cfg_n`=1, no effective busy, and an address below DEPTH-1 that is not the active end address, the address rises by one each clock. `dout` shows the word at the current address, and `dout_oe`=1, `clk_oe`=1 and `ceo_n`=1.
- R3: When the address equals DEPTH-1 and the block is running, the address holds, `dout_oe`=0, `clk_oe`=0 and `ceo_n`=0, in the same cycle the address is reached. This takes precedence over an end-address match and over busy.
- R4: With revisioning on, an address equal to the selected bank's end address and below DEPTH-1 holds the counter, sets `dout_oe`=0 and `clk_oe`=0, and keeps `ceo_n`=1.
- R5: With `ce_n`=0 and `oe_rst`=0, the address is held at the reset target, `dout_oe`=0, `clk_oe`=0 and `ceo_n`=1.
- R6: With `ce_n`=0, `oe_rst`=1 and `cfg_n`=0, the outputs stay driven with the current word and `ceo_n`=1, and the next clock loads the reset target.
- R7: The reset target is the start address of bank `rev_sel` when revisioning is on. It is address 0 when revisioning is off.
- R8: In parallel mode (DW=8) with busy enabled, `busy`=1 holds the address while `dout_oe`=1 and `dout` stays unchanged.
- R9: In serial mode (DW=1), `busy` has no effect and the counter keeps advancing.
- R10: Whenever `dout_oe` is 0, `dout` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and table clock |
| rst_n | input | 1 | Asynchronous active-low reset; loads the bank table |
| ce_n | input | 1 | Chip enable, active low; high means standby |
| oe_rst | input | 1 | High enables output, low holds the address in reset |
| cfg_n | input | 1 | Configuration request, low restarts the address |
| busy | input | 1 | Stall request, honoured only in parallel mode |
| rev_sel | input | 2 | Revision bank select |
| wr_en | input | 1 | Array write strobe (test loading) |
| wr_addr | input | AW | Array write address |
| wr_data | input | DW | Array write word |
| dout | output | DW | Word at the current address, zero when not driven |
| dout_oe | output | 1 | Data bus drive enable |
| clk_oe | output | 1 | Clock output drive enable |
| ceo_n | output | 1 | Cascade enable to the next device, active low |

## Verification
The bench builds two copies of the block. The first is parallel (DW=8, DEPTH=32) with revisioning and busy on. Its four windows are [0,9], [10,19], [20,31] and [5,7], so both an end-address stop short of the top and a window whose end coincides with the top of the array are reachable, as are restarts mid-stream and busy stalls. The second is serial (DW=1, DEPTH=16) with revisioning off. It shows that a nonzero bank select still restarts at address 0, and that busy is ignored all the way up to the top-of-array handover.

// File: rtl/cfg_rom_seq_pkg.sv
package cfg_rom_seq_pkg;
   typedef enum logic [2:0] {
      M_STBY,
      M_HELD,
      M_RESTART,
      M_STALL,
      M_TOP,
      M_WEND,
      M_RUN
   } seq_mode_t;

   localparam int unsigned NSLOT  = 4;
   localparam int unsigned TBL_FW = 16;

   function automatic logic mode_drives(input seq_mode_t m);
      return (m == M_RESTART) || (m == M_STALL) || (m == M_RUN);
   endfunction
endpackage

// File: rtl/crs_store.sv
module crs_store #(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 64,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/crs_bank_tbl.sv
module crs_bank_tbl
   import cfg_rom_seq_pkg::*;
#(
   parameter int unsigned DEPTH  = 64,
   parameter int unsigned NBANK  = 4,
   parameter bit          REV_EN = 1'b1,
   parameter logic [NSLOT*TBL_FW-1:0] START_TBL = '0,
   parameter logic [NSLOT*TBL_FW-1:0] END_TBL   = '0,
   localparam int unsigned AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    rev_sel,
   output logic [AW-1:0] start_addr,
   output logic [AW-1:0] end_addr,
   output logic          end_live
);
   localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

   if (NBANK < 1 || NBANK > NSLOT) begin : g_bad_nbank
      $error("crs_bank_tbl: NBANK must be 1..4");
   end

   if (REV_EN) begin : g_rev
      logic [AW-1:0] st_q [NSLOT];
      logic [AW-1:0] en_q [NSLOT];

      for (genvar b = 0; b < NSLOT; b++) begin : g_slot
         // slots beyond NBANK alias bank 0
         localparam int unsigned SRC = (b < NBANK) ? b : 0;
         localparam int unsigned S_V = START_TBL[SRC*TBL_FW +: TBL_FW];
         localparam int unsigned E_V = END_TBL[SRC*TBL_FW +: TBL_FW];

         if (b < NBANK && (S_V > E_V || E_V >= DEPTH)) begin : g_bad_win
            $error("crs_bank_tbl: bank window out of order or out of range");
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               st_q[b] <= AW'(S_V);
               en_q[b] <= AW'(E_V);
            end else begin
               st_q[b] <= st_q[b];
               en_q[b] <= en_q[b];
            end
         end
      end

      assign start_addr = st_q[rev_sel];
      assign end_addr   = en_q[rev_sel];
      assign end_live   = 1'b1;
   end else begin : g_flat
      assign start_addr = '0;
      assign end_addr   = TOP;
      assign end_live   = 1'b0;
   end
endmodule

// File: rtl/crs_addr_ctl.sv
module crs_addr_ctl
   import cfg_rom_seq_pkg::*;
#(
   parameter int unsigned DEPTH   = 64,
   parameter bit          STALL_EN = 1'b1,
   localparam int unsigned AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          oe_rst,
   input  logic          cfg_n,
   input  logic          busy,
   input  logic [AW-1:0] start_addr,
   input  logic [AW-1:0] end_addr,
   input  logic          end_live,
   output logic [AW-1:0] addr,
   output seq_mode_t     mode
);
   localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("crs_addr_ctl: DEPTH must be at least 2");
   end

   logic          stall_req;
   logic [AW-1:0] addr_d;

   if (STALL_EN) begin : g_stall
      assign stall_req = busy;
   end else begin : g_nostall
      assign stall_req = 1'b0;
   end

   always_comb begin
      if (ce_n)                              mode = M_STBY;
      else if (!oe_rst)                      mode = M_HELD;
      else if (!cfg_n)                       mode = M_RESTART;
      else if (addr == TOP)                  mode = M_TOP;
      else if (end_live && addr == end_addr) mode = M_WEND;
      else if (stall_req)                    mode = M_STALL;
      else                                   mode = M_RUN;
   end

   always_comb begin
      unique case (mode)
         M_STBY, M_HELD, M_RESTART: addr_d = start_addr;
         M_RUN:                     addr_d = addr + 1'b1;
         default:                   addr_d = addr;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) addr <= '0;
      else        addr <= addr_d;
   end

   p_run_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mode == M_RUN |=> addr == AW'($past(addr) + 1'b1));
   p_top_park_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mode == M_TOP |=> addr == $past(addr));
   p_wend_park_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mode == M_WEND |=> addr == $past(addr));
   p_stall_park_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mode == M_STALL |=> addr == $past(addr));
   p_restart_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_STBY || mode == M_HELD || mode == M_RESTART)
      |=> addr == $past(start_addr));
endmodule

// File: rtl/cfg_rom_seq.sv
module cfg_rom_seq
   import cfg_rom_seq_pkg::*;
#(
   parameter int unsigned DW      = 8,
   parameter int unsigned DEPTH   = 64,
   parameter int unsigned NBANK   = 4,
   parameter bit          REV_EN  = 1'b1,
   parameter bit          BUSY_EN = 1'b1,
   parameter logic [NSLOT*TBL_FW-1:0] START_TBL = {16'd48, 16'd32, 16'd16, 16'd0},
   parameter logic [NSLOT*TBL_FW-1:0] END_TBL   = {16'd63, 16'd47, 16'd31, 16'd15},
   localparam int unsigned AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          oe_rst,
   input  logic          cfg_n,
   input  logic          busy,
   input  logic [1:0]    rev_sel,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] dout,
   output logic          dout_oe,
   output logic          clk_oe,
   output logic          ceo_n
);
   // busy is only meaningful on the parallel bus
   localparam bit STALL_LIVE = BUSY_EN && (DW > 1);
   localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

   if (DW != 1 && DW != 8) begin : g_bad_dw
      $error("cfg_rom_seq: DW must be 1 (serial) or 8 (parallel)");
   end

   logic [AW-1:0] addr, start_addr, end_addr;
   logic          end_live;
   logic [DW-1:0] word;
   seq_mode_t     mode;
   logic          drive;

   crs_bank_tbl #(
      .DEPTH(DEPTH), .NBANK(NBANK), .REV_EN(REV_EN),
      .START_TBL(START_TBL), .END_TBL(END_TBL)
   ) u_tbl (
      .clk(clk), .rst_n(rst_n), .rev_sel(rev_sel),
      .start_addr(start_addr), .end_addr(end_addr), .end_live(end_live)
   );

   crs_addr_ctl #(.DEPTH(DEPTH), .STALL_EN(STALL_LIVE)) u_ctl (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_rst(oe_rst),
      .cfg_n(cfg_n), .busy(busy), .start_addr(start_addr),
      .end_addr(end_addr), .end_live(end_live), .addr(addr), .mode(mode)
   );

   crs_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
      .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
      .raddr(addr), .rdata(word)
   );

   assign drive   = mode_drives(mode);
   assign dout_oe = drive;
   assign clk_oe  = drive;
   assign ceo_n   = (mode != M_TOP);
   assign dout    = drive ? word : '0;

   p_standby_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |-> (!dout_oe && !clk_oe && ceo_n));
   p_handover_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ceo_n |-> (addr == TOP && !dout_oe));
   p_held_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !oe_rst) |-> (!dout_oe && ceo_n));
   p_restart_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && oe_rst && !cfg_n) |-> (dout_oe && clk_oe && ceo_n));
   p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_oe |-> dout == '0);
endmodule

// File: tb/sim_cfg_rom_seq.sv
module sim_cfg_rom_seq;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   // parallel copy
   logic       ce0 = 1'b1, oe0 = 1'b1, cf0 = 1'b1, bz0 = 1'b0;
   logic [1:0] rs0 = 2'd0;
   logic       we0 = 1'b0;
   logic [4:0] wa0 = '0;
   logic [7:0] wd0 = '0;
   logic [7:0] q0;
   logic       qoe0, coe0, ceo0;

   // serial copy
   logic       ce1 = 1'b1, oe1 = 1'b1, cf1 = 1'b1, bz1 = 1'b0;
   logic [1:0] rs1 = 2'd0;
   logic       we1 = 1'b0;
   logic [3:0] wa1 = '0;
   logic [0:0] wd1 = '0;
   logic [0:0] q1;
   logic       qoe1, coe1, ceo1;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   cfg_rom_seq #(
      .DW(8), .DEPTH(32), .NBANK(4), .REV_EN(1'b1), .BUSY_EN(1'b1),
      .START_TBL({16'd5, 16'd20, 16'd10, 16'd0}),
      .END_TBL({16'd7, 16'd31, 16'd19, 16'd9})
   ) u0 (
      .clk(clk), .rst_n(rst_n), .ce_n(ce0), .oe_rst(oe0), .cfg_n(cf0),
      .busy(bz0), .rev_sel(rs0), .wr_en(we0), .wr_addr(wa0), .wr_data(wd0),
      .dout(q0), .dout_oe(qoe0), .clk_oe(coe0), .ceo_n(ceo0)
   );

   cfg_rom_seq #(.DW(1), .DEPTH(16), .REV_EN(1'b0), .BUSY_EN(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .ce_n(ce1), .oe_rst(oe1), .cfg_n(cf1),
      .busy(bz1), .rev_sel(rs1), .wr_en(we1), .wr_addr(wa1), .wr_data(wd1),
      .dout(q1), .dout_oe(qoe1), .clk_oe(coe1), .ceo_n(ceo1)
   );

   function automatic int w0(int i);
      return (i * 7 + 3) & 255;
   endfunction

   function automatic int b1(int i);
      return (i % 3 == 0) ? 1 : 0;
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   task automatic load_arrays();
      for (int i = 0; i < 32; i++) begin
         @(negedge clk);
         we0 = 1'b1; wa0 = 5'(i); wd0 = 8'(w0(i));
         we1 = (i < 16); wa1 = 4'(i); wd1 = 1'(b1(i));
      end
      @(negedge clk);
      we0 = 1'b0; we1 = 1'b0;
   endtask

   // standby with the bank chosen, then start running at the bank start
   task automatic go_bank(int b);
      @(negedge clk);
      ce0 = 1'b1; oe0 = 1'b1; cf0 = 1'b1; bz0 = 1'b0; rs0 = 2'(b);
      @(negedge clk);
      ce0 = 1'b0;
      #1;
   endtask

   task automatic t_reset_state();
      #1;
      chk("R1 reset dout_oe", qoe0, 0);
      chk("R1 reset clk_oe", coe0, 0);
      chk("R1 reset ceo_n", ceo0, 1);
      chk("R1 reset serial ceo_n", ceo1, 1);
      chk("R10 reset dout zero", q0, 0);
   endtask

   task automatic t_window_stop();
      go_bank(0);
      for (int k = 0; k < 9; k++) begin
         chk("R2 bank0 word", q0, w0(k));
         chk("R2 bank0 dout_oe", qoe0, 1);
         chk("R2 bank0 ceo_n", ceo0, 1);
         step();
      end
      chk("R4 end dout_oe", qoe0, 0);
      chk("R4 end clk_oe", coe0, 0);
      chk("R4 end ceo_n", ceo0, 1);
      chk("R10 end dout zero", q0, 0);
      step();
      chk("R4 end still parked", qoe0, 0);
      chk("R4 end ceo_n kept", ceo0, 1);
   endtask

   task automatic t_top_handover();
      go_bank(2);
      for (int k = 20; k < 31; k++) begin
         chk("R2 bank2 word", q0, w0(k));
         step();
      end
      chk("R3 top dout_oe", qoe0, 0);
      chk("R3 top clk_oe", coe0, 0);
      chk("R3 top ceo_n", ceo0, 0);
      @(negedge clk);
      bz0 = 1'b1;
      #1;
      chk("R3 top over busy ceo_n", ceo0, 0);
      chk("R3 top over busy dout_oe", qoe0, 0);
      step();
      chk("R3 top still parked", ceo0, 0);
      bz0 = 1'b0;
   endtask

   task automatic t_held_reset();
      @(negedge clk);
      ce0 = 1'b0; oe0 = 1'b0; rs0 = 2'd1;
      #1;
      chk("R5 held dout_oe", qoe0, 0);
      chk("R5 held clk_oe", coe0, 0);
      chk("R5 held ceo_n", ceo0, 1);
      step();
      chk("R5 held second cycle", qoe0, 0);
      @(negedge clk);
      oe0 = 1'b1;
      #1;
      chk("R7 bank1 start word", q0, w0(10));
      chk("R7 bank1 dout_oe", qoe0, 1);
   endtask

   task automatic t_restart();
      go_bank(1);
      repeat (3) @(negedge clk);
      cf0 = 1'b0;
      #1;
      chk("R6 restart current word", q0, w0(13));
      chk("R6 restart dout_oe", qoe0, 1);
      chk("R6 restart clk_oe", coe0, 1);
      chk("R6 restart ceo_n", ceo0, 1);
      @(negedge clk);
      cf0 = 1'b1;
      #1;
      chk("R6 restart reloaded start", q0, w0(10));
      step();
      chk("R2 after restart", q0, w0(11));
   endtask

   task automatic t_busy_stall();
      go_bank(1);
      repeat (2) @(negedge clk);
      bz0 = 1'b1;
      #1;
      chk("R8 stall word", q0, w0(12));
      for (int k = 0; k < 3; k++) begin
         step();
         chk("R8 stall word held", q0, w0(12));
         chk("R8 stall dout_oe", qoe0, 1);
      end
      @(negedge clk);
      bz0 = 1'b0;
      #1;
      chk("R8 released same word", q0, w0(12));
      step();
      chk("R8 released advances", q0, w0(13));
   endtask

   task automatic t_standby();
      @(negedge clk);
      ce0 = 1'b1; oe0 = 1'b1;
      #1;
      chk("R1 standby oe high dout_oe", qoe0, 0);
      chk("R1 standby oe high clk_oe", coe0, 0);
      chk("R1 standby oe high ceo_n", ceo0, 1);
      @(negedge clk);
      oe0 = 1'b0;
      #1;
      chk("R1 standby oe low dout_oe", qoe0, 0);
      chk("R1 standby oe low ceo_n", ceo0, 1);
      @(negedge clk);
      ce0 = 1'b0; oe0 = 1'b1;
      #1;
      chk("R1 standby reset address", q0, w0(10));
   endtask

   task automatic t_short_window();
      go_bank(3);
      chk("R7 bank3 start word", q0, w0(5));
      step();
      chk("R2 bank3 word", q0, w0(6));
      step();
      chk("R4 bank3 end dout_oe", qoe0, 0);
      chk("R4 bank3 end ceo_n", ceo0, 1);
   endtask

   task automatic t_serial();
      @(negedge clk);
      ce1 = 1'b1; rs1 = 2'd3; oe1 = 1'b1; cf1 = 1'b1; bz1 = 1'b1;
      @(negedge clk);
      ce1 = 1'b0;
      #1;
      for (int k = 0; k < 15; k++) begin
         chk(k == 0 ? "R7 serial starts at 0" : "R9 serial ignores busy",
             q1, b1(k));
         chk("R9 serial dout_oe", qoe1, 1);
         step();
      end
      chk("R3 serial top ceo_n", ceo1, 0);
      chk("R3 serial top dout_oe", qoe1, 0);
      chk("R10 serial top dout zero", q1, 0);
      bz1 = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      load_arrays();
      t_window_stop();
      t_top_handover();
      t_held_reset();
      t_restart();
      t_busy_stall();
      t_standby();
      t_short_window();
      t_serial();
      repeat (2) @(negedge clk);
      finish_up();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_up();
   end
endmodule